// File: doc/BRIEF.md
# Serial-Configured Ten-Way Clock Fanout with Per-Output Stop

This block passes one input clock to ten outputs. Each output can be stopped low on its own, and one enable input can float all ten at once. A two-wire serial slave holds the enable bits in a small bank of configuration bytes. The slave does only two kinds of transfer:

- **Write.** After the address, the first two bytes are accepted and dropped. Every later byte loads the bank in order, starting at byte zero.
- **Read.** The slave first sends a length byte. It then sends the bank in order, followed by fixed filler bytes.

The bus lines are sampled with the system clock. The gating runs in the input-clock domain, so an output that starts or stops never produces a shortened pulse.

Top module: `clkFanoutCfg`

## Requirements
- R1: The block acknowledges address byte 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the rest of that transfer leaves the bank unchanged.
- R2: In a write, the two bytes after the address are acknowledged and their values are never stored.
- R3: Write data bytes fill bank byte 0, then 1, then 2. A Stop after any complete byte leaves the bytes not reached unchanged.
- R4: Write data bytes beyond the third are acknowledged and discarded.
- R5: A read returns 0x07 first. It then returns bank bytes 0, 1 and 2, followed by 0xFF for every later byte.
- R6: Output enables map to bank bits as follows: outputs 3..0 from byte 0 bits 3..0, outputs 9..8 from byte 1 bits 7..6, and outputs 7..4 from byte 2 bits 7..4. All eight bits of each byte read back as written.
- R7: An enable bit of 1 lets its output follow the input clock. An enable bit of 0 holds that output low.
- R8: After reset, every bank byte is 0xFF and all ten outputs run.
- R9: While `driveEn` is low, all ten output enables are low, whatever the bank holds. While it is high, all ten are high.
- R10: An output changes between running and stopped only while the input clock is low. No output rises while the input clock is low, and no output falls while it is high.
- R11: A Start in the middle of a transfer aborts it, and the block begins address matching again.
- R12: When the master does not acknowledge a read byte, the block releases the data line and drives nothing more until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOut | output | 1 | Value driven on the data line (always low, open drain) |
| sdaOe | output | 1 | Data line driver enable; high pulls the line low |
| bufClk | input | 1 | Clock that is fanned out |
| driveEn | input | 1 | Global output enable; low puts all outputs in high impedance |
| clkOut | output | 10 | Gated copies of `bufClk` |
| clkOutOe | output | 10 | Per-output driver enables |

## Verification
The main function is exercised in three ways:

- **Seeded random writes.** Random payload lengths from zero to five bytes, with random dummy bytes, separate R2 from R4 and show whether a short Stop leaves later bytes alone. Each write is followed by a full read-back and by an output check taken in both phases of the input clock.
- **Directed bank patterns.** Sparse patterns place single ones in each mapped field and in the reserved bits, which exposes any swapped or shifted field in the enable map. An all-zero pattern checks the stopped-low level.
- **Protocol corner cases.** A foreign address, an aborted write that restarts as a read, an aborted write that restarts as a write, and an early read NACK each test the protocol state machine on its own.

A monitor on every output edge looks for a rise during the clock's low phase or a fall during its high phase. Either one would mean a gate switched at the wrong time.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;
  localparam int OUT_COUNT = 10;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic shiftIn;   // capture the sampled data bit
    logic wrReg;     // store the received byte at idx
    logic loadTx;    // load the transmit shifter for read slot idx
    logic shiftOut;  // advance the transmit shifter
  } strobe_t;
endpackage

// File: rtl/fanBusCtrl.sv
`timescale 1ns/1ps
module fanBusCtrl
  import clkfan_pkg::*;
#(
  parameter int         IDX_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic             sdaBit,
  output logic             sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} state_t;

  logic [1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclNow, sdaNow;
  logic startDet, stopDet, sclRise, sclFall;
  state_t state;
  logic [3:0] bitCnt;
  logic isAddr, readMode, nackQ;
  logic [IDX_W-1:0] byteNum, rdIdx;

  // Two-flop filter plus one history stage for edge detection
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign startDet = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopDet  = sclNow & sclQ & ~sdaQ & sdaNow;
  assign sclRise  = sclNow & ~sclQ;
  assign sclFall  = ~sclNow & sclQ;

  always_comb begin
    stb.shiftIn  = (state == S_RX) && sclRise && (bitCnt < 4'd8);
    stb.wrReg    = (state == S_RX) && sclFall && (bitCnt == 4'd8) && !isAddr &&
                   (byteNum >= IDX_W'(2));
    stb.loadTx   = sclFall && (((state == S_ACK) && readMode) ||
                               ((state == S_RACK) && !nackQ));
    stb.shiftOut = (state == S_TX) && sclFall && (bitCnt != 4'd7);
  end

  assign idx    = readMode ? rdIdx : byteNum - IDX_W'(2);
  assign sdaBit = sdaNow;
  assign sdaOe  = (state == S_ACK) | ((state == S_TX) & ~txBit);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      isAddr   <= 1'b0;
      readMode <= 1'b0;
      nackQ    <= 1'b0;
      byteNum  <= '0;
      rdIdx    <= '0;
    end else if (startDet) begin
      state    <= S_RX;
      bitCnt   <= '0;
      isAddr   <= 1'b1;
      readMode <= 1'b0;
      byteNum  <= '0;
      rdIdx    <= '0;
    end else if (stopDet) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_RX: begin
          if (stb.shiftIn) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (isAddr && rxByte[7:1] != DEV_ADDR) begin
              state <= S_IDLE;
            end else begin
              state <= S_ACK;
              if (isAddr) readMode <= rxByte[0];
              else if (byteNum != '1) byteNum <= byteNum + IDX_W'(1);
            end
          end
        end
        S_ACK: if (sclFall) begin
          bitCnt <= '0;
          isAddr <= 1'b0;
          state  <= readMode ? S_TX : S_RX;
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 4'd7) state <= S_RACK;
          else bitCnt <= bitCnt + 4'd1;
        end
        S_RACK: begin
          if (sclRise) nackQ <= sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= nackQ ? S_IDLE : S_TX;
          end
        end
        default: ;
      endcase
      if (stb.loadTx && rdIdx != '1) rdIdx <= rdIdx + IDX_W'(1);
    end
  end

  AST_SDA_MOVES_AFTER_FALL: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall)); // R1
  AST_NO_STORE_IN_READ: assert property (@(posedge sysClk) disable iff (!rstN)
    stb.wrReg |-> !readMode); // R2
  AST_START_RESTARTS: assert property (@(posedge sysClk) disable iff (!rstN)
    startDet |=> (state == S_RX) && isAddr && (bitCnt == 4'd0)); // R11
  AST_STOP_RELEASES: assert property (@(posedge sysClk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R12
endmodule

// File: rtl/fanCfgData.sv
`timescale 1ns/1ps
module fanCfgData
  import clkfan_pkg::*;
#(
  parameter int         NUM_REG  = 3,
  parameter int         IDX_W    = 4,
  parameter int         READ_LEN = 7,
  parameter logic [7:0] REG_INIT = 8'hFF
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 sdaBit,
  output logic [7:0]           rxByte,
  output logic                 txBit,
  output logic [OUT_COUNT-1:0] enBits
);
  logic [7:0] rxShift, txShift, txLoad;
  logic [NUM_REG-1:0][7:0] regs;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (stb.loadTx) txShift <= txLoad;
      else if (stb.shiftOut) txShift <= {txShift[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic [7:0] regQ;
    always_ff @(posedge sysClk or negedge rstN) begin
      if (!rstN) regQ <= REG_INIT;
      else if (stb.wrReg && idx == IDX_W'(g)) regQ <= rxShift;
    end
    assign regs[g] = regQ;
  end

  // Read slot 0 is the length, slots 1..NUM_REG the bank, the rest filler
  always_comb begin
    txLoad = 8'hFF;
    if (idx == '0) txLoad = 8'(READ_LEN);
    for (int k = 0; k < NUM_REG; k++)
      if (idx == IDX_W'(k + 1)) txLoad = regs[k];
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];
  assign enBits = {regs[1][7:6], regs[2][7:4], regs[0][3:0]};

  AST_BANK_HOLDS: assert property (@(posedge sysClk) disable iff (!rstN)
    !stb.wrReg |=> $stable(regs)); // R3
  AST_LENGTH_FIRST: assert property (@(posedge sysClk) disable iff (!rstN)
    (stb.loadTx && idx == '0) |=> txShift == 8'(READ_LEN)); // R5
endmodule

// File: rtl/fanClkGate.sv
`timescale 1ns/1ps
module fanClkGate #(
  parameter int NUM_OUT = 10
) (
  input  logic               bufClk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] enIn,
  input  logic               driveEn,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] clkOutOe
);
  // Synchronizer and gate both update on the falling edge, so the gate
  // only moves while the clock is low
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic syncQ, gateQ;
    always_ff @(negedge bufClk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 1'b1;
        gateQ <= 1'b1;
      end else begin
        syncQ <= enIn[g];
        gateQ <= syncQ;
      end
    end
    assign clkOut[g] = bufClk & gateQ;
  end

  assign clkOutOe = {NUM_OUT{driveEn}};
endmodule

// File: rtl/clkFanoutCfg.sv
`timescale 1ns/1ps
module clkFanoutCfg
  import clkfan_pkg::*;
#(
  parameter int         NUM_REG  = 3,
  parameter int         IDX_W    = 4,
  parameter int         READ_LEN = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOut,
  output logic        sdaOe,
  input  logic        bufClk,
  input  logic        driveEn,
  output logic [9:0]  clkOut,
  output logic [9:0]  clkOutOe
);
  strobe_t stb;
  logic [IDX_W-1:0] idx;
  logic [7:0] rxByte;
  logic txBit, sdaBit;
  logic [OUT_COUNT-1:0] enBits;

  assign sdaOut = 1'b0;

  fanBusCtrl #(.IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .sysClk(sysClk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .idx(idx),
    .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  fanCfgData #(.NUM_REG(NUM_REG), .IDX_W(IDX_W), .READ_LEN(READ_LEN)) u_data (
    .sysClk(sysClk), .rstN(rstN), .stb(stb), .idx(idx), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .enBits(enBits)
  );

  fanClkGate #(.NUM_OUT(OUT_COUNT)) u_gate (
    .bufClk(bufClk), .rstN(rstN), .enIn(enBits), .driveEn(driveEn),
    .clkOut(clkOut), .clkOutOe(clkOutOe)
  );
endmodule

// File: tb/clkFanoutCfg_bench.sv
`timescale 1ns/1ps
module clkFanoutCfg_bench;
  localparam int Q = 8;

  logic sysClk = 1'b0, bufClk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, driveEn = 1'b1;
  logic sdaOut, sdaOe;
  logic [9:0] clkOut, clkOutOe;
  wire sdaLine = sdaM & ~(sdaOe & ~sdaOut);

  int nChk = 0, nBad = 0, runtCnt = 0;
  bit done = 1'b0;
  logic [7:0] expReg [3];
  logic [9:0] prevOut = '0;

  always #10 sysClk = ~sysClk;
  always #15 bufClk = ~bufClk;

  clkFanoutCfg u_clkFanoutCfg (
    .sysClk(sysClk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .bufClk(bufClk), .driveEn(driveEn),
    .clkOut(clkOut), .clkOutOe(clkOutOe)
  );

  // R10 monitor: a rise only with the clock high, a fall only with it low
  always @(clkOut) begin
    for (int i = 0; i < 10; i++) begin
      if (clkOut[i] === 1'b1 && prevOut[i] === 1'b0 && bufClk === 1'b0) runtCnt++;
      if (clkOut[i] === 1'b0 && prevOut[i] === 1'b1 && bufClk === 1'b1) runtCnt++;
    end
    prevOut = clkOut;
  end

  function automatic logic [9:0] expEn();
    return {expReg[1][7:6], expReg[2][7:4], expReg[0][3:0]};
  endfunction

  function automatic logic [7:0] expRd(int k);
    if (k == 0) return 8'h07;
    if (k <= 3) return expReg[k-1];
    return 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic waitSys(int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic busStart();
    waitSys(Q); sdaM = 1'b1; waitSys(Q); sclM = 1'b1; waitSys(Q);
    sdaM = 1'b0; waitSys(Q); sclM = 1'b0; waitSys(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitSys(Q); sclM = 1'b1; waitSys(Q); sdaM = 1'b1; waitSys(Q);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitSys(Q); sclM = 1'b1; waitSys(Q);
    s = sdaLine; waitSys(Q); sclM = 1'b0; waitSys(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) clockBit(b[i], dummy);
    clockBit(1'b1, ack);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    logic s, dummy;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      b = {b[6:0], s};
    end
    clockBit(nack, dummy);
  endtask

  task automatic writeTxn(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                          input logic [7:0] d [6], input string tag);
    logic a;
    busStart();
    sendByte(8'hD2, a); chk(a == 1'b0, "R1", "write address ack", a, 0);
    sendByte(cmd, a);   chk(a == 1'b0, "R2", "command byte ack", a, 0);
    sendByte(cnt, a);   chk(a == 1'b0, "R2", "count byte ack", a, 0);
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], a);
      chk(a == 1'b0, tag, "data byte ack", a, 0);
      if (k < 3) expReg[k] = d[k];
    end
    busStop();
  endtask

  task automatic readAll(input string tag);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, a); chk(a == 1'b0, "R1", "read address ack", a, 0);
    for (int k = 0; k < 8; k++) begin
      recvByte(k == 7, b);
      chk(b == expRd(k), tag, $sformatf("read slot %0d", k), b, expRd(k));
    end
    busStop();
  endtask

  task automatic checkOutputs(input string tag);
    repeat (6) @(negedge bufClk);
    @(posedge bufClk); #5;
    chk(clkOut == expEn(), tag, "outputs in high phase", clkOut, expEn());
    chk(clkOutOe == 10'h3FF, "R9", "output enables with driveEn high", clkOutOe, 10'h3FF);
    @(negedge bufClk); #5;
    chk(clkOut == 10'h000, "R7", "outputs in low phase", clkOut, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] d [6];
    void'($urandom(32'd4711));
    for (int k = 0; k < 3; k++) expReg[k] = 8'hFF;
    repeat (5) @(negedge sysClk);
    rstN = 1'b1;
    waitSys(4);

    // R8: reset state
    chk(sdaOe == 1'b0, "R8", "data line released after reset", sdaOe, 0);
    checkOutputs("R8");
    readAll("R5");

    // R1: foreign addresses are ignored
    busStart();
    sendByte(8'hA4, a); chk(a == 1'b1, "R1", "foreign address not acked", a, 1);
    sendByte(8'h00, a); sendByte(8'h00, a); sendByte(8'h00, a);
    chk(a == 1'b1, "R1", "later bytes not acked", a, 1);
    busStop();
    busStart();
    sendByte(8'hD0, a); chk(a == 1'b1, "R1", "near address not acked", a, 1);
    sendByte(8'h00, a);
    busStop();
    readAll("R1");

    // R2: dummy bytes only
    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    writeTxn(8'hAA, 8'h55, 0, d, "R2");
    readAll("R2");

    // R3: a single data byte, the other bytes remain
    d = '{8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    writeTxn(8'h99, 8'h01, 1, d, "R3");
    readAll("R3");

    // R4: overlong write
    d = '{8'h05, 8'h40, 8'hA0, 8'h00, 8'h11, 8'h22};
    writeTxn(8'h00, 8'h06, 6, d, "R4");
    readAll("R4");
    // R6: sparse bits in each field give outputs 0,2,8,5,7
    checkOutputs("R6");

    // R7: everything stopped low
    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    writeTxn(8'h00, 8'h03, 3, d, "R7");
    checkOutputs("R7");

    // R9: global float
    d = '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00};
    writeTxn(8'h00, 8'h03, 3, d, "R9");
    driveEn = 1'b0; waitSys(1);
    chk(clkOutOe == 10'h000, "R9", "enables low with driveEn low", clkOutOe, 0);
    driveEn = 1'b1; waitSys(1);
    chk(clkOutOe == 10'h3FF, "R9", "enables back high", clkOutOe, 10'h3FF);

    // R11: abort a write and restart as a write, then abort into a read
    busStart();
    sendByte(8'hD2, a); sendByte(8'h11, a);
    busStart();
    sendByte(8'hD2, a); chk(a == 1'b0, "R11", "address after restart", a, 0);
    sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h3C, a); chk(a == 1'b0, "R11", "data after restart", a, 0);
    expReg[0] = 8'h3C;
    busStop();
    busStart();
    sendByte(8'hD2, a); sendByte(8'h77, a);
    readAll("R11");

    // R12: early NACK ends the read
    busStart();
    sendByte(8'hD3, a);
    recvByte(1'b0, b); chk(b == 8'h07, "R12", "length before NACK", b, 8'h07);
    recvByte(1'b1, b); chk(b == expReg[0], "R12", "byte 0 before NACK", b, expReg[0]);
    waitSys(2);
    chk(sdaOe == 1'b0, "R12", "line released after NACK", sdaOe, 0);
    recvByte(1'b1, b); chk(b == 8'hFF, "R12", "no drive after NACK", b, 8'hFF);
    busStop();

    // Seeded random writes with varying length
    for (int it = 0; it < 10; it++) begin
      int n;
      n = $urandom_range(0, 5);
      for (int k = 0; k < 6; k++) d[k] = 8'($urandom);
      writeTxn(8'($urandom), 8'($urandom), n, d, n > 3 ? "R4" : "R3");
      checkOutputs("R6");
      readAll("R5");
    end

    chk(runtCnt == 0, "R10", "edges outside their clock phase", runtCnt, 0);
    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    #3_800_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL ALL watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule